// File: doc/BRIEF.md
# Serial Flash Write-Access Guard

This block sits behind the instruction decoder of a serial NOR flash slave and decides, one instruction at a time, whether that instruction may run. It also holds the status bits that the decision depends on: the busy flag, the write-enable latch, the two status-protection bits and a quad-mode bit. Serial shifting, array timing and the real non-volatile cells are outside it. The protection bits and the quad bit start at their factory values and are not cleared by an ordinary power-on reset. The one exception is the power-cycle lock code, which a power-on reset returns to the unlocked code.

The decoder presents one instruction per cycle as a valid strobe with an operation code. The guard answers one cycle later with a single-cycle accept or reject pulse. The array sequencer reports that a program, erase or status write has finished with a one-cycle done pulse. A tick input drives a lockout counter. The counter restarts whenever reset is asserted, and while it runs every instruction that could change stored data is refused.

Top module: `flash_wr_guard`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy, write-enable, accept and reject are 0. The power-down state is off after reset.
- R2: An accepted write-enable instruction sets the write-enable latch. An accepted write-disable instruction clears it.
- R3: Page program, each erase kind and write-status are rejected while the write-enable latch is 0, and the status bits do not change.
- R4: An accepted program, erase or write-status sets busy in the next cycle. A done pulse while busy clears both busy and the write-enable latch. A done pulse while idle has no effect.
- R5: While busy, only read-status and erase-suspend are accepted and every other instruction is rejected. An instruction that arrives in the same cycle as a done pulse is judged against the busy state.
- R6: Until LOCK_TICKS ticks have been counted after reset is released, write-enable, program, every erase and write-status are rejected.
- R7: With protection code 00, a write-status with the write-enable latch set is accepted whatever the level of the write-protect pin.
- R8: With protection code 01 and quad mode off, a write-status is rejected while wp_n is 0 and accepted while wp_n is 1. With quad mode on, wp_n is ignored.
- R9: With protection code 10 or 11, every write-status is rejected. A power-on reset turns code 10 into 00 and leaves code 11 unchanged.
- R10: After an accepted power-down instruction, every instruction except release-power-down is rejected. An accepted release ends the power-down state.
- R11: Each valid instruction gives exactly one of accept or reject, one cycle later. A cycle without a valid instruction gives neither. A rejected instruction leaves all status bits unchanged.
- R12: The protection code and quad bit carried by a write-status are stored when its done pulse arrives, not when the instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Time base for the power-up lockout |
| cmd_valid | input | 1 | Instruction strobe |
| cmd_op | input | 4 | Decoded operation code (package enum) |
| wrsr_srp | input | 2 | Protection code carried by a write-status |
| wrsr_qe | input | 1 | Quad-mode bit carried by a write-status |
| wp_n | input | 1 | Active-low write-protect pin |
| op_done | input | 1 | Sequencer completion pulse |
| cmd_accept | output | 1 | One-cycle accept pulse |
| cmd_reject | output | 1 | One-cycle reject pulse |
| busy | output | 1 | Operation in progress |
| wel | output | 1 | Write-enable latch |
| srp | output | 2 | Protection code, bit 1 = SRP1, bit 0 = SRP0 |

## Verification
The completion pulse from the sequencer and a new instruction can arrive in the same cycle. In that case busy and the write-enable latch fall on the same edge at which the instruction is judged. The bench drives a write-enable together with the done pulse that ends a sector erase. It expects a reject, with busy and the write-enable latch both 0 afterwards. It also sends a done pulse alone while the block is idle and the latch is set, and expects every status bit to stay as it was.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef enum logic [3:0] {
        OP_WREN = 4'd0,
        OP_WRDI = 4'd1,
        OP_PROG = 4'd2,
        OP_SE   = 4'd3,
        OP_BE32 = 4'd4,
        OP_BE64 = 4'd5,
        OP_CE   = 4'd6,
        OP_WRSR = 4'd7,
        OP_RDSR = 4'd8,
        OP_SUSP = 4'd9,
        OP_PD   = 4'd10,
        OP_RPD  = 4'd11
    } fwg_op_e;

    typedef struct packed {
        logic busy;
        logic wel;
        logic pd;
        logic pend_wrsr;
    } fwg_state_t;

    typedef struct packed {
        logic [1:0] srp;
        logic       qe;
    } fwg_nv_t;

    localparam logic [1:0] SRP_SOFT  = 2'b00;
    localparam logic [1:0] SRP_HW    = 2'b01;
    localparam logic [1:0] SRP_CYCLE = 2'b10;

    function automatic logic is_array_op(input fwg_op_e op);
        return (op == OP_PROG) || (op == OP_SE) || (op == OP_BE32) ||
               (op == OP_BE64) || (op == OP_CE);
    endfunction

    function automatic logic starts_busy(input fwg_op_e op);
        return is_array_op(op) || (op == OP_WRSR);
    endfunction

endpackage

// File: rtl/fwg_lockout.sv
module fwg_lockout #(
    parameter int LOCK_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic locked
);
    localparam int CW = $clog2(LOCK_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_TICKS);

    logic [CW-1:0] cnt_q;

    assign locked = (cnt_q != LIMIT);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick && locked)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/fwg_protect.sv
module fwg_protect
    import fwg_pkg::*;
(
    input  fwg_nv_t nv,
    input  logic    wp_n,
    output logic    sr_write_ok
);
    always_comb begin
        unique case (nv.srp)
            SRP_SOFT: sr_write_ok = 1'b1;
            SRP_HW:   sr_write_ok = nv.qe | wp_n;
            default:  sr_write_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fwg_decide.sv
module fwg_decide
    import fwg_pkg::*;
(
    input  logic       cmd_valid,
    input  fwg_op_e    cmd_op,
    input  fwg_state_t st,
    input  logic       locked,
    input  logic       sr_write_ok,
    output logic       take,
    output logic       refuse
);
    logic allowed;

    always_comb begin
        if (st.pd) begin
            allowed = (cmd_op == OP_RPD);
        end else if (st.busy) begin
            allowed = (cmd_op == OP_RDSR) || (cmd_op == OP_SUSP);
        end else begin
            unique case (cmd_op)
                OP_WREN:                            allowed = !locked;
                OP_PROG, OP_SE, OP_BE32, OP_BE64,
                OP_CE:                              allowed = !locked && st.wel;
                OP_WRSR:                            allowed = !locked && st.wel && sr_write_ok;
                OP_WRDI, OP_RDSR, OP_SUSP, OP_PD,
                OP_RPD:                             allowed = 1'b1;
                default:                            allowed = 1'b0;
            endcase
        end
    end

    assign take   = cmd_valid && allowed;
    assign refuse = cmd_valid && !allowed;
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
    import fwg_pkg::*;
#(
    parameter int LOCK_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic [1:0] wrsr_srp,
    input  logic       wrsr_qe,
    input  logic       wp_n,
    input  logic       op_done,
    output logic       cmd_accept,
    output logic       cmd_reject,
    output logic       busy,
    output logic       wel,
    output logic [1:0] srp
);
    fwg_op_e    op;
    fwg_state_t st_q;
    fwg_nv_t    nv_q = '{srp: SRP_SOFT, qe: 1'b0};
    fwg_nv_t    pend_q;
    logic       locked, sr_write_ok, take, refuse;
    logic       acc_q, rej_q;
    logic       finish;

    assign op     = fwg_op_e'(cmd_op);
    assign finish = op_done && st_q.busy;

    fwg_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .locked (locked)
    );

    fwg_protect u_prot (
        .nv          (nv_q),
        .wp_n        (wp_n),
        .sr_write_ok (sr_write_ok)
    );

    fwg_decide u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (op),
        .st          (st_q),
        .locked      (locked),
        .sr_write_ok (sr_write_ok),
        .take        (take),
        .refuse      (refuse)
    );

    // volatile state and answer pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            pend_q <= '0;
            acc_q  <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            acc_q <= take;
            rej_q <= refuse;
            if (finish) begin
                st_q.busy      <= 1'b0;
                st_q.wel       <= 1'b0;
                st_q.pend_wrsr <= 1'b0;
            end
            if (take) begin
                unique case (op)
                    OP_WREN: st_q.wel <= 1'b1;
                    OP_WRDI: st_q.wel <= 1'b0;
                    OP_PD:   st_q.pd  <= 1'b1;
                    OP_RPD:  st_q.pd  <= 1'b0;
                    default: ;
                endcase
                if (starts_busy(op)) begin
                    st_q.busy      <= 1'b1;
                    st_q.pend_wrsr <= (op == OP_WRSR);
                    pend_q         <= '{srp: wrsr_srp, qe: wrsr_qe};
                end
            end
        end
    end

    // non-volatile bits: a power cycle only releases the cycle lock
    always_ff @(posedge clk) begin
        if (rst) begin
            if (nv_q.srp == SRP_CYCLE)
                nv_q.srp <= SRP_SOFT;
        end else if (finish && st_q.pend_wrsr) begin
            nv_q <= pend_q;
        end
    end

    assign cmd_accept = acc_q;
    assign cmd_reject = rej_q;
    assign busy       = st_q.busy;
    assign wel        = st_q.wel;
    assign srp        = nv_q.srp;
endmodule

// File: rtl/fwg_chk.sv
module fwg_chk
    import fwg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       op_done,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic       busy,
    input logic       wel,
    input logic [1:0] srp,
    input fwg_state_t st_q
);
    // R11
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject));

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !(cmd_accept || cmd_reject));

    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && busy) |=> (!busy && !wel));

    // R3
    need_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !wel && (is_array_op(fwg_op_e'(cmd_op)) ||
         cmd_op == OP_WRSR)) |=> cmd_reject);

    // R5
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy && cmd_op == OP_WREN) |=> cmd_reject);

    // R10
    pd_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && st_q.pd && cmd_op != OP_RPD) |=> cmd_reject);

    // R9
    otp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (srp == 2'b11) |=> (srp == 2'b11));

    // R2
    wrdi_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_WRDI && !busy && !st_q.pd) |=> !wel);
endmodule

bind flash_wr_guard fwg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .op_done    (op_done),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .busy       (busy),
    .wel        (wel),
    .srp        (srp),
    .st_q       (st_q)
);

// File: tb/flash_wr_guard_tb.sv
module flash_wr_guard_tb;
    import fwg_pkg::*;

    localparam int LOCK = 4;

    typedef struct packed {
        logic       vld;
        fwg_op_e    op;
        logic       wp;
        logic [1:0] sd;
        logic       qd;
        logic       dn;
        logic       ea;
        logic       er;
        logic       eb;
        logic       ew;
        logic [1:0] es;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b1, OP_PROG, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd3},  // R3
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 4'd2},  // R2
        '{1'b1, OP_PROG, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 4'd4},  // R4
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 4'd5},  // R5
        '{1'b1, OP_RDSR, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 4'd5},  // R5
        '{1'b0, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd4},  // R4
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 4'd2},  // R2
        '{1'b1, OP_WRSR, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 4'd7},  // R7 R12
        '{1'b0, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 4'd12}, // R12
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 4'd2},  // R2
        '{1'b1, OP_WRSR, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 4'd8},  // R8
        '{1'b1, OP_WRSR, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 4'd8},  // R8
        '{1'b0, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 4'd8},  // R8
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 4'd2},  // R2
        '{1'b1, OP_WRSR, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 4'd8},  // R8 quad
        '{1'b0, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 4'd9},  // R9
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 4'd2},  // R2
        '{1'b1, OP_WRSR, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 4'd9},  // R9
        '{1'b1, OP_WRDI, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 4'd2},  // R2
        '{1'b1, OP_PD,   1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 4'd10}, // R10
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 4'd10}, // R10
        '{1'b1, OP_RDSR, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 4'd10}, // R10
        '{1'b1, OP_RPD,  1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 4'd10}, // R10
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 4'd2},  // R2
        '{1'b1, OP_SE,   1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 4'd4},  // R4
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 4'd5},  // R5 same-cycle done
        '{1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 4'd2},  // R2
        '{1'b0, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'd4},  // R4 idle done
        '{1'b1, OP_WRDI, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 4'd2}   // R2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [1:0] wrsr_srp = '0;
    logic       wrsr_qe = 1'b0;
    logic       wp_n = 1'b1;
    logic       op_done = 1'b0;
    logic       cmd_accept, cmd_reject, busy, wel;
    logic [1:0] srp;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    flash_wr_guard #(.LOCK_TICKS(LOCK)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .wrsr_srp   (wrsr_srp),
        .wrsr_qe    (wrsr_qe),
        .wp_n       (wp_n),
        .op_done    (op_done),
        .cmd_accept (cmd_accept),
        .cmd_reject (cmd_reject),
        .busy       (busy),
        .wel        (wel),
        .srp        (srp)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {acc,rej,busy,wel,srp} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {cmd_accept, cmd_reject, busy, wel, srp};
    endfunction

    task automatic step(input logic v, input fwg_op_e op, input logic w,
                        input logic [1:0] sd, input logic qd, input logic dn);
        cmd_valid = v; cmd_op = op; wp_n = w; wrsr_srp = sd; wrsr_qe = qd; op_done = dn;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; op_done = 1'b0; wp_n = 1'b1;
    endtask

    task automatic por();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", outs() & 6'b111100, 6'b000000);
        rst = 1'b0;
        @(negedge clk);
        check("R1", outs() & 6'b111100, 6'b000000);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por();
        // R6: write enable refused during the lockout window
        step(1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R6", outs(), 6'b010000);
        step(1'b1, OP_WRDI, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R6", outs(), 6'b100000);
        repeat (LOCK + 2) @(negedge clk);
        step(1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R6", outs(), 6'b100100);
        step(1'b1, OP_WRDI, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R2", outs(), 6'b100000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].vld, VEC[i].op, VEC[i].wp, VEC[i].sd, VEC[i].qd, VEC[i].dn);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), outs(),
                  {VEC[i].ea, VEC[i].er, VEC[i].eb, VEC[i].ew, VEC[i].es});
        end

        // R9: power cycle releases code 10
        por();
        check("R9", {4'b0, srp}, 6'b000000);
        repeat (LOCK + 2) @(negedge clk);
        step(1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0);
        step(1'b1, OP_WRSR, 1'b1, 2'b11, 1'b0, 1'b0);
        check("R7", outs(), 6'b101100);
        step(1'b0, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b1);
        check("R12", outs(), 6'b000011);
        // R9: code 11 survives a power cycle and still blocks
        por();
        check("R9", {4'b0, srp}, 6'b000011);
        repeat (LOCK + 2) @(negedge clk);
        step(1'b1, OP_WREN, 1'b1, 2'b00, 1'b0, 1'b0);
        step(1'b1, OP_WRSR, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R9", outs(), 6'b010111);
        // R11: no command, no pulse
        step(1'b0, OP_WRSR, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R11", outs(), 6'b000111);

        finish_run();
    end
endmodule